// File: doc/BRIEF.md
# Externally Scheduled Context Switch Controller

This block selects which of four hardware thread contexts owns the single datapath of a block-multithreaded core. A hardware scheduler outside the core can force any named context to run at once, and gives the block a mask of the contexts that hold live threads. When the running thread signals that it has finished, the block picks the next context itself. The search is round-robin and runs over the live contexts that have not yet finished.

Each context keeps a finished flag, and these flags are reported back to the scheduler. When no live, unfinished context is left, the block stops and waits for the scheduler. Every switch flushes the pipeline. An execute-valid flag stays low while the pipeline refills, so the scheduler can see exactly when the new thread begins useful work.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `halted_o`=1, `run_ctx_o`=0, `done_o`=0, `flush_o`=0 and `exec_o`=0.
- R2: A scheduler request (`sched_req_i`=1) sampled at a clock edge makes `run_ctx_o` equal to the sampled `sched_target_i` (binary context number 0..3) and clears `halted_o` in the cycle that follows.
- R3: In the same update, the active mask is replaced by `sched_active_i` (bit i means context i). The `done_o` bits of contexts whose mask bit goes from 0 to 1 are cleared, and so is the done bit of the target. All other done bits keep their value.
- R4: `term_i`=1 while running, with no scheduler request, sets `done_o` bit i of the running context i in the next cycle.
- R5: After such a termination, the next running context is the first context that is both active and not done. The search starts at the running context plus one, wraps modulo 4, and the new context takes over one cycle later.
- R6: If no context is eligible, `halted_o`=1 and `run_ctx_o` keeps its value. The halt persists, and `term_i` is ignored (done bits unchanged), until the next scheduler request.
- R7: If a scheduler request and `term_i` arrive in the same cycle, the request is served and the termination has no effect. In particular, the running context's done bit is not set.
- R8: `flush_o` is high for exactly one cycle on every switch, whether external or internal, in the cycle where `run_ctx_o` first shows the new context. It never pulses on entry to halt.
- R9: `exec_o` is low during the flush cycle and the four cycles after it (five in total), then high, unless another switch restarts the count. It is low whenever `halted_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sched_req_i | input | 1 | Scheduler forces a switch this cycle |
| sched_target_i | input | 2 | Context number to start on a forced switch |
| sched_active_i | input | 4 | Live-context mask, latched with a forced switch |
| term_i | input | 1 | Running thread reports that it has finished |
| run_ctx_o | output | 2 | Number of the context that owns the datapath |
| done_o | output | 4 | Finished flag per context |
| halted_o | output | 1 | No context is running |
| flush_o | output | 1 | One-cycle pipeline flush on a switch |
| exec_o | output | 1 | Running context is past its refill window |

## Verification
The running context, the done flags, the halt state and the flush pulse all settle one clock edge after the stimulus is sampled. The execute-valid flag rises only on the fifth edge after a switch. The driver applies each stimulus on a falling edge and pushes the matching expected output set into a queue. The monitor pops one entry and compares it a quarter period after the next rising edge, so every result is read exactly one edge after its cause. Runs of idle steps after each switch walk the refill window edge by edge until the flag rises.

// File: rtl/ctxsw_pkg.sv
// Shared constants and types of the context switch controller.
// Assumes four contexts by default; other power-of-two counts also work.
package ctxsw_pkg;
    localparam int unsigned CTXSW_NUM_CTX = 4;
    localparam int unsigned CTXSW_REFILL  = 5;

    // Why the running context changes in a given cycle
    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_EXT  = 2'd1,
        SW_INT  = 2'd2,
        SW_HALT = 2'd3
    } sw_cause_e;
endpackage

// File: rtl/ctxsw_rr_pick.sv
// Round-robin picker: finds the first set bit of elig_i at offset 1..N
// from cur_i, wrapping modulo N. Purely combinational.
// Assumes that NUM_CTX is at least 2.
module ctxsw_rr_pick #(
    parameter int unsigned NUM_CTX = ctxsw_pkg::CTXSW_NUM_CTX,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
    input  logic [CTX_W-1:0]   cur_i,
    input  logic [NUM_CTX-1:0] elig_i,
    output logic               found_o,
    output logic [CTX_W-1:0]   idx_o
);
    // Rotate the eligible mask so that bit k is context cur+1+k
    logic [NUM_CTX-1:0] rot;

    genvar g;
    generate
        for (g = 0; g < NUM_CTX; g++) begin : g_rot
            localparam int unsigned OFS = g + 1;
            logic [CTX_W:0] sum;
            assign sum      = {1'b0, cur_i} + (CTX_W+1)'(OFS);
            assign rot[g]   = elig_i[(int'(sum)) % NUM_CTX];
        end
    endgenerate

    // Lowest rotated bit wins: scan from the far end so the nearest overwrites
    always_comb begin
        found_o = 1'b0;
        idx_o   = cur_i;
        for (int k = NUM_CTX - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found_o = 1'b1;
                idx_o   = CTX_W'((int'(cur_i) + k + 1) % NUM_CTX);
            end
        end
    end
endmodule

// File: rtl/ctxsw_done_track.sv
// Holds the latched active mask and the per-context finished flags.
// A load replaces the mask and clears the flags of newly activated
// contexts and of the load target; a set marks one context finished.
// Assumes that load and set are never both high (the top gives load priority).
module ctxsw_done_track #(
    parameter int unsigned NUM_CTX = ctxsw_pkg::CTXSW_NUM_CTX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NUM_CTX-1:0] mask_i,
    input  logic [NUM_CTX-1:0] tgt_oh_i,
    input  logic               set_i,
    input  logic [NUM_CTX-1:0] set_oh_i,
    output logic [NUM_CTX-1:0] active_o,
    output logic [NUM_CTX-1:0] done_o
);
    logic [NUM_CTX-1:0] active_q, done_q, done_d, fresh;

    // Contexts going from inactive to active on this load
    assign fresh = mask_i & ~active_q;

    // Next-state of the finished flags
    always_comb begin
        done_d = done_q;
        if (load_i) begin
            done_d = done_q & ~(fresh | tgt_oh_i);
        end else if (set_i) begin
            done_d = done_q | set_oh_i;
        end
    end

    // Flag and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            done_q   <= '0;
        end else begin
            done_q <= done_d;
            if (load_i) begin
                active_q <= mask_i;
            end
        end
    end

    assign active_o = active_q;
    assign done_o   = done_q;
endmodule

// File: rtl/ctxsw_refill_timer.sv
// Models the pipeline refill after a switch: a one-cycle flush pulse,
// then a down-counter that keeps busy_o high for REFILL cycles in total.
// Assumes REFILL >= 1; a new start restarts the window.
module ctxsw_refill_timer #(
    parameter int unsigned REFILL = ctxsw_pkg::CTXSW_REFILL,
    localparam int unsigned CNT_W = $clog2(REFILL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic flush_o,
    output logic busy_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             flush_q;

    // Load the window on a switch, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            flush_q <= 1'b0;
        end else if (start_i) begin
            cnt_q   <= CNT_W'(REFILL);
            flush_q <= 1'b1;
        end else begin
            flush_q <= 1'b0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign flush_o = flush_q;
    assign busy_o  = (cnt_q != '0);
endmodule

// File: rtl/ctx_switch_ctrl.sv
// Top of the context switch controller. It arbitrates between a forced
// switch from the external scheduler and a termination of the running
// thread, keeps the running context and halt state, and drives the
// refill timer. Assumes that term_i belongs to the context on run_ctx_o.
module ctx_switch_ctrl #(
    parameter int unsigned NUM_CTX = ctxsw_pkg::CTXSW_NUM_CTX,
    parameter int unsigned REFILL  = ctxsw_pkg::CTXSW_REFILL,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sched_req_i,
    input  logic [CTX_W-1:0]   sched_target_i,
    input  logic [NUM_CTX-1:0] sched_active_i,
    input  logic               term_i,
    output logic [CTX_W-1:0]   run_ctx_o,
    output logic [NUM_CTX-1:0] done_o,
    output logic               halted_o,
    output logic               flush_o,
    output logic               exec_o
);
    import ctxsw_pkg::*;

    logic [CTX_W-1:0]   run_q;
    logic               halted_q;
    logic [NUM_CTX-1:0] run_oh, tgt_oh, active, done, elig;
    logic               term_ok, found, busy, switch_now;
    logic [CTX_W-1:0]   pick;
    sw_cause_e          cause;

    // One-hot forms of the running context and the requested target
    always_comb begin
        run_oh = '0;
        tgt_oh = '0;
        run_oh[run_q]          = 1'b1;
        tgt_oh[sched_target_i] = 1'b1;
    end

    // Termination counts only when running and not overridden
    assign term_ok = term_i && !halted_q && !sched_req_i;

    // Candidates after a termination: live, unfinished, not the one leaving
    assign elig = active & ~(done | run_oh);

    ctxsw_rr_pick #(.NUM_CTX(NUM_CTX)) pick_i (
        .cur_i   (run_q),
        .elig_i  (elig),
        .found_o (found),
        .idx_o   (pick)
    );

    // Classify this cycle's event; the scheduler has priority
    always_comb begin
        if (sched_req_i) begin
            cause = SW_EXT;
        end else if (term_ok && found) begin
            cause = SW_INT;
        end else if (term_ok) begin
            cause = SW_HALT;
        end else begin
            cause = SW_NONE;
        end
    end

    assign switch_now = (cause == SW_EXT) || (cause == SW_INT);

    ctxsw_done_track #(.NUM_CTX(NUM_CTX)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (sched_req_i),
        .mask_i   (sched_active_i),
        .tgt_oh_i (tgt_oh),
        .set_i    (term_ok),
        .set_oh_i (run_oh),
        .active_o (active),
        .done_o   (done)
    );

    // Running context and halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            halted_q <= 1'b1;
        end else begin
            case (cause)
                SW_EXT: begin
                    run_q    <= sched_target_i;
                    halted_q <= 1'b0;
                end
                SW_INT:  run_q    <= pick;
                SW_HALT: halted_q <= 1'b1;
                default: ;
            endcase
        end
    end

    ctxsw_refill_timer #(.REFILL(REFILL)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (switch_now),
        .flush_o (flush_o),
        .busy_o  (busy)
    );

    assign run_ctx_o = run_q;
    assign done_o    = done;
    assign halted_o  = halted_q;
    assign exec_o    = !halted_q && !busy;
endmodule

// File: rtl/ctx_switch_ctrl_chk.sv
// Port-level property checker for ctx_switch_ctrl, attached by bind.
module ctx_switch_ctrl_chk #(
    parameter int unsigned NUM_CTX = ctxsw_pkg::CTXSW_NUM_CTX,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sched_req_i,
    input logic [CTX_W-1:0]   sched_target_i,
    input logic [NUM_CTX-1:0] sched_active_i,
    input logic               term_i,
    input logic [CTX_W-1:0]   run_ctx_o,
    input logic [NUM_CTX-1:0] done_o,
    input logic               halted_o,
    input logic               flush_o,
    input logic               exec_o
);
    // R2
    ext_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_req_i |=> (run_ctx_o == $past(sched_target_i)) && !halted_o);

    // R3
    ext_no_new_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_req_i |=> ((done_o & ~$past(done_o)) == '0));

    // R4
    term_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !sched_req_i && !halted_o) |=> done_o[$past(run_ctx_o)]);

    // R6
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !sched_req_i) |=> halted_o && $stable(run_ctx_o) && $stable(done_o));

    // R8
    flush_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_req_i |=> flush_o);

    // R8
    quiet_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_req_i && !term_i) |=> !flush_o);

    // R9
    exec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o || halted_o) |-> !exec_o);
endmodule

bind ctx_switch_ctrl ctx_switch_ctrl_chk #(.NUM_CTX(NUM_CTX)) chk_i (.*);

// File: tb/ctx_switch_ctrl_tb_top.sv
module ctx_switch_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sched_req_i;
    logic [1:0] sched_target_i;
    logic [3:0] sched_active_i;
    logic       term_i;
    logic [1:0] run_ctx_o;
    logic [3:0] done_o;
    logic       halted_o, flush_o, exec_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] run;
        logic [3:0] done;
        logic       halt;
        logic       flush;
        logic       exec;
    } exp_t;

    exp_t sb_q[$];

    // Reference state, built from the requirements
    logic [1:0] m_run;
    logic [3:0] m_done, m_act;
    logic       m_halt, m_flush;
    int         m_cnt;

    always #10 clk = ~clk;  // 50 MHz

    ctx_switch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .sched_req_i(sched_req_i), .sched_target_i(sched_target_i),
        .sched_active_i(sched_active_i), .term_i(term_i),
        .run_ctx_o(run_ctx_o), .done_o(done_o), .halted_o(halted_o),
        .flush_o(flush_o), .exec_o(exec_o)
    );

    task automatic compare(input exp_t e);
        tests++;
        if (run_ctx_o !== e.run || done_o !== e.done || halted_o !== e.halt ||
            flush_o !== e.flush || exec_o !== e.exec) begin
            fails++;
            $display("FAIL %s: got run=%0d done=%b halt=%b flush=%b exec=%b, expected run=%0d done=%b halt=%b flush=%b exec=%b",
                     e.tag, run_ctx_o, done_o, halted_o, flush_o, exec_o,
                     e.run, e.done, e.halt, e.flush, e.exec);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic req, input logic [1:0] tgt,
                        input logic [3:0] act, input logic term, input string tag);
        exp_t e;
        bit   hit;
        @(negedge clk);
        sched_req_i    = req;
        sched_target_i = tgt;
        sched_active_i = act;
        term_i         = term;
        if (req) begin
            m_done         = m_done & ~(act & ~m_act);
            m_done[tgt]    = 1'b0;
            m_act          = act;
            m_run          = tgt;
            m_halt         = 1'b0;
            m_flush        = 1'b1;
            m_cnt          = 5;
        end else if (term && !m_halt) begin
            m_done[m_run] = 1'b1;
            hit = 1'b0;
            for (int k = 1; k <= 4; k++) begin
                int c;
                c = (int'(m_run) + k) % 4;
                if (!hit && m_act[c] && !m_done[c]) begin
                    hit   = 1'b1;
                    m_run = 2'(c);
                end
            end
            m_flush = hit;
            if (hit) m_cnt = 5;
            else begin
                m_halt = 1'b1;
                if (m_cnt > 0) m_cnt--;
            end
        end else begin
            m_flush = 1'b0;
            if (m_cnt > 0) m_cnt--;
        end
        e.tag = tag; e.run = m_run; e.done = m_done; e.halt = m_halt;
        e.flush = m_flush; e.exec = !m_halt && (m_cnt == 0);
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 4'd0, 1'b0, tag);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t r;
        rst_n = 1'b0; sched_req_i = 1'b0; sched_target_i = '0;
        sched_active_i = '0; term_i = 1'b0;
        m_run = '0; m_done = '0; m_act = '0; m_halt = 1'b1; m_flush = 1'b0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #5;
        r.tag = "R1 in reset"; r.run = 0; r.done = 0; r.halt = 1; r.flush = 0; r.exec = 0;
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 2'd0, 4'd0, 1'b0, "R1 after reset");
        // R2 R3 R8: forced start of context 2, live set {1,3}
        step(1'b1, 2'd2, 4'b1010, 1'b0, "R2 forced switch");
        idle(5, "R9 refill window");
        // R4 R5: context 2 ends, next live is 3
        step(1'b0, 2'd0, 4'd0, 1'b1, "R5 round robin to 3");
        idle(2, "R9 refill");
        // R5 wrap: 3 ends, search 0 (inactive) then 1
        step(1'b0, 2'd0, 4'd0, 1'b1, "R5 wrap to 1");
        idle(5, "R9 refill");
        // R6: 1 ends, nothing eligible
        step(1'b0, 2'd0, 4'd0, 1'b1, "R6 enter halt");
        step(1'b0, 2'd0, 4'd0, 1'b1, "R6 term ignored in halt");
        idle(2, "R6 stays halted");
        // R7 R3: forced switch with simultaneous term, all live
        step(1'b1, 2'd0, 4'b1111, 1'b1, "R7 request beats term");
        idle(5, "R9 refill");
        step(1'b0, 2'd0, 4'd0, 1'b1, "R4 term marks 0 done");
        idle(2, "R9 refill");
        // R7: same-target request during refill with term
        step(1'b1, 2'd2, 4'b1111, 1'b1, "R7 restart same ctx");
        idle(3, "R9 refill restarted");
        // R3: shrink live set, only target cleared
        step(1'b1, 2'd3, 4'b1101, 1'b0, "R3 mask shrink");
        idle(5, "R9 refill");
        step(1'b0, 2'd0, 4'd0, 1'b1, "R5 wrap 3 to 2");
        idle(5, "R9 refill");
        step(1'b0, 2'd0, 4'd0, 1'b1, "R6 halt again");
        idle(2, "R9 exec low in halt");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule